// File: doc/BRIEF.md
# Special Character Interrupt Unit

This block sits beside a UART receiver and turns notable receive events into sticky interrupt flags. It compares every received character against four programmable flow-control characters (two resume, two pause). It measures how long the raw receive line stays low so that a line break can be reported. It also reports address characters, marked by a set 9th bit, when 9-bit multidrop mode is on. The flags form one 8-bit register that is cleared when it is read.

A per-flag enable mask gates the flags into a single summary interrupt. The mask only decides which flags reach the summary output; the flags themselves are recorded whatever the mask says. Break timing uses a one-per-bit tick from the receiver's baud generator. The character length it is compared against comes from the configured data bits, parity and stop bits.

Top module: `spchar_irq_unit`

## Requirements
- R1: After a synchronous reset, every flag is 0, `irq` is 0 and `rd_data` is 0.
- R2: A read (`rd_en`=1) at address 0x06 loads `rd_data` on the next edge with the flags as they were before that edge. Bit 0 is resume-1, bit 1 is resume-2, bit 2 is pause-1, bit 3 is pause-2, bit 4 is break and bit 5 is multidrop address, and bits 7:6 are 0. A read at any other address returns 0 and leaves the flags untouched.
- R3: A read at address 0x06 clears every flag, so an immediate second read returns 0.
- R4: With `cfg_special_en`=1, a character strobed by `rx_valid` whose 8 data bits equal a programmed match character sets that character's flag. With `cfg_special_en`=0, none of the four flow-control flags sets.
- R5: With `cfg_multidrop_en`=1, a character strobed with `rx_bit9`=1 sets flag bit 5. With the mode off, or with `rx_bit9`=0, bit 5 stays 0.
- R6: The break flag (bit 4) sets on the bit tick that finds the line low for the (L+1)-th consecutive tick, where L = 1 + (5 + `cfg_data_bits`) + `cfg_parity_en` + (`cfg_two_stop` ? 2 : 1). After only L low ticks it is still 0.
- R7: The break flag sets once per low period. The detector re-arms only after the synchronised line has been seen high.
- R8: When a flag's set event and a read at 0x06 fall in the same cycle, that flag is 1 after the read.
- R9: `irq` is the OR over the six flags of flag AND `irq_mask` bit, with the mask bits in the same order as the flags. It is updated on the same edge as the flags. Flags are held regardless of the mask.
- R10: A character that equals several programmed match characters sets every matching flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received character data bits |
| rx_bit9 | input | 1 | 9th bit of the received character (address marker) |
| rx_line | input | 1 | Raw asynchronous receive line, idle high |
| bit_tick | input | 1 | One-cycle pulse once per bit time |
| cfg_special_en | input | 1 | Enables flow-control character matching |
| cfg_multidrop_en | input | 1 | Enables 9-bit multidrop address detection |
| cfg_data_bits | input | 2 | Data bits per character minus 5 |
| cfg_parity_en | input | 1 | One parity bit per character |
| cfg_two_stop | input | 1 | Two stop bits instead of one |
| match_on1 | input | 8 | Resume character 1 |
| match_on2 | input | 8 | Resume character 2 |
| match_off1 | input | 8 | Pause character 1 |
| match_off2 | input | 8 | Pause character 2 |
| irq_mask | input | 6 | Per-flag enables for the summary interrupt |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Registered summary interrupt |

## Verification
A corrupted flag bit shows on `irq` one edge after the faulty update when its mask bit is set. It shows on `rd_data` at the next read of 0x06 whatever the mask. A flag that fails to clear appears as a nonzero second read in the cycle after the first one. A break counter that is off by one fires a tick early or late against the computed length. It can also fire again within the same low period, and the read after each group of ticks catches that.

// File: rtl/spchar_pkg.sv
package spchar_pkg;
  localparam int NUM_FLAGS = 6;
  localparam int REG_W     = 8;
  localparam int CHAR_W    = 8;
  localparam int NUM_MATCH = 4;
  localparam int MIN_DATA  = 5;
  localparam int MAX_LEN   = 1 + 8 + 1 + 2;
  localparam int LEN_W     = $clog2(MAX_LEN + 1);
  localparam int FLG_ON1   = 0;
  localparam int FLG_ON2   = 1;
  localparam int FLG_OFF1  = 2;
  localparam int FLG_OFF2  = 3;
  localparam int FLG_BRK   = 4;
  localparam int FLG_ADDR  = 5;
endpackage

// File: rtl/spchar_matcher.sv
module spchar_matcher
  import spchar_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            rx_valid,
  input  logic [CHAR_W-1:0]               rx_data,
  input  logic                            rx_bit9,
  input  logic                            special_en,
  input  logic                            multidrop_en,
  input  logic [NUM_MATCH-1:0][CHAR_W-1:0] match_chars,
  output logic [NUM_MATCH-1:0]            fc_set,
  output logic                            addr_set
);
  logic [NUM_MATCH-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NUM_MATCH; g++) begin : g_cmp
      assign hit[g] = (rx_data == match_chars[g]);
    end
  endgenerate

  always_comb begin
    fc_set   = (rx_valid && special_en) ? hit : '0;
    addr_set = rx_valid && multidrop_en && rx_bit9;
  end

  // R4: flow-control sets need the mode and a strobe
  a_r4_fc_gated: assert property (@(posedge clk) disable iff (rst)
    (|fc_set) |-> (special_en && rx_valid));
  // R5: address set needs the 9th bit
  a_r5_addr_gated: assert property (@(posedge clk) disable iff (rst)
    addr_set |-> (rx_bit9 && multidrop_en));
endmodule

// File: rtl/spchar_break_det.sv
module spchar_break_det
  import spchar_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_line,
  input  logic       bit_tick,
  input  logic [1:0] cfg_data_bits,
  input  logic       cfg_parity_en,
  input  logic       cfg_two_stop,
  output logic       brk_set
);
  logic             line_s;
  logic [LEN_W-1:0] char_len;
  logic [LEN_W-1:0] cnt_q;
  logic             armed_q;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= 1'b1;
        else     s_q <= rx_line;
      end
      assign line_s = s_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= '1;
        else     s_q <= {s_q[SYNC_STAGES-2:0], rx_line};
      end
      assign line_s = s_q[SYNC_STAGES-1];
    end
  endgenerate

  always_comb begin
    char_len = LEN_W'(1 + MIN_DATA) + LEN_W'(cfg_data_bits)
             + LEN_W'(cfg_parity_en) + (cfg_two_stop ? LEN_W'(2) : LEN_W'(1));
  end

  assign brk_set = bit_tick && !line_s && armed_q && (cnt_q >= char_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (line_s) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (bit_tick) begin
      if (brk_set)
        armed_q <= 1'b0;
      else if (cnt_q < char_len)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7: a high line clears the low-period count
  a_r7_rearm_clears: assert property (@(posedge clk) disable iff (rst)
    line_s |=> (cnt_q == '0 && armed_q));
  // R7: one break per low period
  a_r7_single_fire: assert property (@(posedge clk) disable iff (rst)
    brk_set |=> !armed_q);
  // R6: counter never passes the limit
  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LEN_W'(MAX_LEN));
endmodule

// File: rtl/spchar_flag_reg.sv
module spchar_flag_reg
  import spchar_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h06
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic [NUM_FLAGS-1:0] mask_i,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [REG_W-1:0]     rd_data,
  output logic                 irq
);
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] flag_d;
  logic                 rd_hit;

  assign rd_hit = rd_en && (rd_addr == FLAG_ADDR);

  always_comb begin
    if (rd_hit) flag_d = set_i;
    else        flag_d = flag_q | set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= '0;
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq    <= |(flag_d & mask_i);
      if (rd_en)
        rd_data <= rd_hit ? {{(REG_W-NUM_FLAGS){1'b0}}, flag_q} : '0;
    end
  end

  // R3: a read leaves only same-cycle sets
  a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (flag_q == $past(set_i)));
  // R8: a set always lands
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));
  // R9: flags held without a read
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  // R9: summary follows masked flags
  a_r9_irq_gate: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |(flag_q & $past(mask_i))));
  // R2: read data reflects pre-read flags
  a_r2_read_value: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (rd_data == {{(REG_W-NUM_FLAGS){1'b0}}, $past(flag_q)}));
endmodule

// File: rtl/spchar_irq_unit.sv
module spchar_irq_unit
  import spchar_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR   = 8'h06,
  parameter int                SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_bit9,
  input  logic              rx_line,
  input  logic              bit_tick,
  input  logic              cfg_special_en,
  input  logic              cfg_multidrop_en,
  input  logic [1:0]        cfg_data_bits,
  input  logic              cfg_parity_en,
  input  logic              cfg_two_stop,
  input  logic [7:0]        match_on1,
  input  logic [7:0]        match_on2,
  input  logic [7:0]        match_off1,
  input  logic [7:0]        match_off2,
  input  logic [5:0]        irq_mask,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              irq
);
  logic [NUM_MATCH-1:0][CHAR_W-1:0] match_chars;
  logic [NUM_MATCH-1:0]             fc_set;
  logic                             addr_set;
  logic                             brk_set;
  logic [NUM_FLAGS-1:0]             set_vec;

  always_comb begin
    match_chars[FLG_ON1]  = match_on1;
    match_chars[FLG_ON2]  = match_on2;
    match_chars[FLG_OFF1] = match_off1;
    match_chars[FLG_OFF2] = match_off2;
    set_vec               = '0;
    set_vec[FLG_OFF2:FLG_ON1] = fc_set;
    set_vec[FLG_BRK]      = brk_set;
    set_vec[FLG_ADDR]     = addr_set;
  end

  spchar_matcher u_match (
    .clk          (clk),
    .rst          (rst),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_bit9      (rx_bit9),
    .special_en   (cfg_special_en),
    .multidrop_en (cfg_multidrop_en),
    .match_chars  (match_chars),
    .fc_set       (fc_set),
    .addr_set     (addr_set)
  );

  spchar_break_det #(.SYNC_STAGES(SYNC_STAGES)) u_brk (
    .clk           (clk),
    .rst           (rst),
    .rx_line       (rx_line),
    .bit_tick      (bit_tick),
    .cfg_data_bits (cfg_data_bits),
    .cfg_parity_en (cfg_parity_en),
    .cfg_two_stop  (cfg_two_stop),
    .brk_set       (brk_set)
  );

  spchar_flag_reg #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_i   (set_vec),
    .mask_i  (irq_mask),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq     (irq)
  );
endmodule

// File: tb/spchar_irq_unit_tb.sv
module spchar_irq_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_bit9 = 1'b0;
  logic       rx_line = 1'b1;
  logic       bit_tick = 1'b0;
  logic       cfg_special_en = 1'b0;
  logic       cfg_multidrop_en = 1'b0;
  logic [1:0] cfg_data_bits = 2'd3;
  logic       cfg_parity_en = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic [7:0] match_on1 = 8'h11;
  logic [7:0] match_on2 = 8'h12;
  logic [7:0] match_off1 = 8'h13;
  logic [7:0] match_off2 = 8'h14;
  logic [5:0] irq_mask = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h06;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  spchar_irq_unit u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_line(rx_line), .bit_tick(bit_tick),
    .cfg_special_en(cfg_special_en), .cfg_multidrop_en(cfg_multidrop_en),
    .cfg_data_bits(cfg_data_bits), .cfg_parity_en(cfg_parity_en),
    .cfg_two_stop(cfg_two_stop), .match_on1(match_on1), .match_on2(match_on2),
    .match_off1(match_off1), .match_off2(match_off2), .irq_mask(irq_mask),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // fields: special, multidrop, data, bit9, mask, expected flags, expected irq
  localparam logic [23:0] VEC [0:8] = '{
    {1'b1, 1'b0, 8'h11, 1'b0, 6'h3F, 6'h01, 1'b1},
    {1'b1, 1'b0, 8'h12, 1'b0, 6'h00, 6'h02, 1'b0},
    {1'b1, 1'b0, 8'h13, 1'b0, 6'h04, 6'h04, 1'b1},
    {1'b1, 1'b0, 8'h14, 1'b0, 6'h03, 6'h08, 1'b0},
    {1'b0, 1'b0, 8'h11, 1'b0, 6'h3F, 6'h00, 1'b0},
    {1'b1, 1'b1, 8'h55, 1'b1, 6'h20, 6'h20, 1'b1},
    {1'b1, 1'b0, 8'h55, 1'b1, 6'h3F, 6'h00, 1'b0},
    {1'b1, 1'b1, 8'h11, 1'b1, 6'h3F, 6'h21, 1'b1},
    {1'b1, 1'b1, 8'hAA, 1'b0, 6'h3F, 6'h00, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send_char(input logic [7:0] d, input logic b9);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_bit9 = b9;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0; rd_addr = 8'h06;
    v = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
  endtask

  task automatic set_line(input logic v);
    @(negedge clk); rx_line = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    do_read(8'h06, rv);
    check("R1 flags", rv, 8'h00);

    for (int i = 0; i < 9; i++) begin
      logic [23:0] v;
      v = VEC[i];
      irq_mask = v[12:7];
      cfg_special_en = v[23];
      cfg_multidrop_en = v[22];
      send_char(v[21:14], v[13]);
      check($sformatf("R9 irq vec%0d", i), {7'd0, irq}, {7'd0, v[0]});
      do_read(8'h06, rv);
      check($sformatf("R4/R5/R2 flags vec%0d", i), rv, {2'b00, v[6:1]});
    end
    cfg_multidrop_en = 1'b0;
    irq_mask = '0;

    // R2: other address returns 0 and does not clear
    send_char(8'h11, 1'b0);
    do_read(8'h05, rv);
    check("R2 other addr", rv, 8'h00);
    do_read(8'h06, rv);
    check("R2 not cleared", rv, 8'h01);
    do_read(8'h06, rv);
    check("R3 cleared", rv, 8'h00);

    // R8: set and read in the same cycle
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h13; rd_en = 1'b1; rd_addr = 8'h06;
    @(negedge clk);
    rx_valid = 1'b0; rd_en = 1'b0;
    check("R8 read old", rd_data, 8'h00);
    do_read(8'h06, rv);
    check("R8 set kept", rv, 8'h04);

    // R10: duplicate programmed characters
    match_off2 = 8'h11;
    send_char(8'h11, 1'b0);
    do_read(8'h06, rv);
    check("R10 multi match", rv, 8'h09);
    match_off2 = 8'h14;

    // R6: 8 data, no parity, one stop -> L=10
    irq_mask = 6'h10;
    set_line(1'b0);
    ticks(10);
    do_read(8'h06, rv);
    check("R6 not at L", rv, 8'h00);
    ticks(1);
    @(negedge clk);
    check("R6 irq", {7'd0, irq}, 8'h01);
    do_read(8'h06, rv);
    check("R6 break set", rv, 8'h10);
    ticks(15);
    do_read(8'h06, rv);
    check("R7 once per low", rv, 8'h00);
    ticks(1);
    set_line(1'b1);
    ticks(2);
    set_line(1'b0);
    ticks(11);
    do_read(8'h06, rv);
    check("R7 rearmed", rv, 8'h10);
    set_line(1'b1);

    // R6: 8 data, parity, two stop -> L=12
    cfg_parity_en = 1'b1; cfg_two_stop = 1'b1;
    set_line(1'b0);
    ticks(12);
    do_read(8'h06, rv);
    check("R6 not at L=12", rv, 8'h00);
    ticks(1);
    do_read(8'h06, rv);
    check("R6 set at L+1=13", rv, 8'h10);
    set_line(1'b1);

    // R6: 5 data, no parity, one stop -> L=7
    cfg_parity_en = 1'b0; cfg_two_stop = 1'b0; cfg_data_bits = 2'd0;
    set_line(1'b0);
    ticks(7);
    do_read(8'h06, rv);
    check("R6 not at L=7", rv, 8'h00);
    ticks(1);
    do_read(8'h06, rv);
    check("R6 set at L+1=8", rv, 8'h10);
    set_line(1'b1);

    // R1: reset clears a held flag
    send_char(8'h12, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    do_read(8'h06, rv);
    check("R1 reset clears", rv, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule